// File: doc/BRIEF.md
# Block Quantizer and Variable-Length Code Packer

This block turns one 8x8 block of signed transform coefficients into a compact byte stream. Software or an upstream engine first loads the 64 coefficients through a write port, addressed in raster order (row times eight plus column), and then pulses `start`. The block divides every coefficient by eight with an arithmetic right shift. It walks the block along the anti-diagonals, starting at the top-left corner. Each quantized value is replaced by a fixed prefix-free code, and the codes are packed most significant bit first into bytes.

Values that have no entry in the code table are sent as an escape prefix followed by the value in two's complement. Bytes leave through a valid/ready handshake. When `byte_ready` is low the stream waits and no bits are lost. After the last code, any partial byte is filled with ones and sent. `busy` then falls, and a new block may be loaded and started.

Top module: `qzh_block_coder`

## Requirements
- R1: Out of reset `busy` and `byte_valid` are both low.
- R2: Each coefficient is quantized as an arithmetic right shift by QSHIFT (default 3), which rounds toward negative infinity (for example -1 becomes -1 and -9 becomes -2).
- R3: Codes are emitted in zigzag order: position k=0 is raster address 0, k=1 is row 0 column 1 (address 1), k=2 is row 1 column 0 (address 8), k=3 is address 16. Even anti-diagonals run from bottom-left to top-right, odd ones from top-right to bottom-left.
- R4: Short codes (bits written first to last): -1 is 00, 0 is 100, 1 is 010, -2 is 110, 2 is 1110, 3 is 1010, 5 is 0110.
- R5: Longer codes: -3 is 11110, -5 is 10110, -10 is 01110, -4 is 101110, -8 is 101111, -9 is 111110, 6 is 011111, 14 is 011110, and 144 is 1111110.
- R6: A quantized value that is not in the table is sent as 1111111 followed by its low ESC_W bits (COEF_W minus QSHIFT, 12 by default) in two's complement, sign bit first.
- R7: Bits are packed most significant bit first: the first bit of the stream is bit 7 of the first byte.
- R8: If the stream length is not a multiple of eight, the last byte carries the remaining bits in its upper positions and ones below them. If the length is a multiple of eight, no extra byte is sent.
- R9: While `byte_valid` is high and `byte_ready` is low, `byte_valid` and `byte_data` hold their values. The byte sequence does not depend on how `byte_ready` is throttled.
- R10: While `busy` is high, `start` and coefficient writes are ignored: the running block is neither restarted nor altered, and the stored coefficients keep their values for the next block.
- R11: `busy` rises in the cycle after an accepted `start` and stays high until the final byte has been taken. While `busy` is low, `byte_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 6 | Raster address of the coefficient (row*8+column) |
| coef_data | input | COEF_W | Signed coefficient value |
| start | input | 1 | Begin coding the stored block |
| busy | output | 1 | Block is being coded or drained |
| byte_valid | output | 1 | `byte_data` holds a byte of the stream |
| byte_ready | input | 1 | Consumer takes the byte when high together with `byte_valid` |
| byte_data | output | 8 | Packed stream byte |

## Verification
The bench uses the default parameters: 15-bit coefficients and a shift of three. This gives a 12-bit escape field and a quantized range of exactly -2048 to 2047, so the most negative and most positive coefficients land on the two ends of the escape field. With these defaults every table entry can be reached with each of the eight remainders that the floor shift discards. The longest code, 19 bits, also shows up in the packer while up to seven earlier bits are still waiting there.

// File: rtl/qzh_pkg.sv
package qzh_pkg;

    localparam int BLK_SIDE = 8;
    localparam int BLK_AREA = BLK_SIDE * BLK_SIDE;
    localparam int ADDR_W   = $clog2(BLK_AREA);
    localparam int PFX_W    = 7;
    localparam int BYTE_W   = 8;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_FEED,
        SQ_DRAIN
    } seq_state_e;

    typedef struct packed {
        logic       hit;
        logic [2:0] len;
        logic [6:0] bits;
    } vlc_t;

    // Zigzag position k -> raster address (row*8+col), computed per diagonal.
    function automatic logic [ADDR_W-1:0] zz_raster(input logic [ADDR_W-1:0] k);
        int kk;
        int base;
        int len;
        int off;
        int r;
        int c;
        logic [ADDR_W-1:0] res;
        kk   = int'(k);
        base = 0;
        res  = '0;
        for (int s = 0; s < 2 * BLK_SIDE - 1; s++) begin
            len = (s < BLK_SIDE) ? s + 1 : 2 * BLK_SIDE - 1 - s;
            if (kk >= base && kk < base + len) begin
                off = kk - base;
                if (s % 2 == 1) begin
                    r = ((s > BLK_SIDE - 1) ? s - (BLK_SIDE - 1) : 0) + off;
                end else begin
                    r = ((s < BLK_SIDE) ? s : BLK_SIDE - 1) - off;
                end
                c   = s - r;
                res = ADDR_W'(r * BLK_SIDE + c);
            end
            base = base + len;
        end
        return res;
    endfunction

    // Fixed prefix-free table; miss means escape.
    function automatic vlc_t vlc_lookup(input int v);
        vlc_t t;
        t.hit = 1'b1;
        t.len = 3'd0;
        t.bits = 7'd0;
        case (v)
            -1:  begin t.len = 3'd2; t.bits = 7'b0000000; end
            0:   begin t.len = 3'd3; t.bits = 7'b0000100; end
            1:   begin t.len = 3'd3; t.bits = 7'b0000010; end
            -2:  begin t.len = 3'd3; t.bits = 7'b0000110; end
            2:   begin t.len = 3'd4; t.bits = 7'b0001110; end
            3:   begin t.len = 3'd4; t.bits = 7'b0001010; end
            5:   begin t.len = 3'd4; t.bits = 7'b0000110; end
            -3:  begin t.len = 3'd5; t.bits = 7'b0011110; end
            -5:  begin t.len = 3'd5; t.bits = 7'b0010110; end
            -10: begin t.len = 3'd5; t.bits = 7'b0001110; end
            -4:  begin t.len = 3'd6; t.bits = 7'b0101110; end
            -8:  begin t.len = 3'd6; t.bits = 7'b0101111; end
            -9:  begin t.len = 3'd6; t.bits = 7'b0111110; end
            6:   begin t.len = 3'd6; t.bits = 7'b0011111; end
            14:  begin t.len = 3'd6; t.bits = 7'b0011110; end
            144: begin t.len = 3'd7; t.bits = 7'b1111110; end
            default: begin t.hit = 1'b0; t.len = 3'd0; t.bits = 7'b1111111; end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/qzh_coef_bank.sv
module qzh_coef_bank
    import qzh_pkg::*;
#(
    parameter int COEF_W = 15
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic                     lock,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic signed [COEF_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic signed [COEF_W-1:0] rd_data
);

    logic signed [COEF_W-1:0] cell_q [BLK_AREA];

    always_ff @(posedge clk) begin
        if (wr_en && !lock) begin
            cell_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cell_q[rd_addr];

endmodule

// File: rtl/qzh_zz_sequencer.sv
module qzh_zz_sequencer
    import qzh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              take_ready,
    input  logic              pack_empty,
    output logic              feed_valid,
    output logic              drain,
    output logic              busy,
    output logic [ADDR_W-1:0] raster_addr
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(BLK_AREA - 1);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        state_q <= SQ_FEED;
                        idx_q   <= '0;
                    end
                end
                SQ_FEED: begin
                    if (take_ready) begin
                        if (idx_q == LAST_IDX) begin
                            state_q <= SQ_DRAIN;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                SQ_DRAIN: begin
                    if (pack_empty) begin
                        state_q <= SQ_IDLE;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign feed_valid  = (state_q == SQ_FEED);
    assign drain       = (state_q == SQ_DRAIN);
    assign busy        = (state_q != SQ_IDLE);
    assign raster_addr = zz_raster(idx_q);

    // R9
    feed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (feed_valid && !take_ready) |=> (feed_valid && $stable(idx_q)));

    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_FEED) |=> ((idx_q == $past(idx_q)) || (idx_q == $past(idx_q) + 1'b1)));

endmodule

// File: rtl/qzh_code_map.sv
module qzh_code_map
    import qzh_pkg::*;
#(
    parameter int COEF_W = 15,
    parameter int QSHIFT = 3,
    parameter int ESC_W  = COEF_W - QSHIFT,
    parameter int MAX_W  = PFX_W + ESC_W,
    parameter int LEN_W  = $clog2(MAX_W + 1)
) (
    input  logic signed [COEF_W-1:0] coef,
    output logic [MAX_W-1:0]         code_bits,
    output logic [LEN_W-1:0]         code_len
);

    logic signed [COEF_W-1:0] quant;
    vlc_t                     hit_code;

    assign quant    = coef >>> QSHIFT;
    assign hit_code = vlc_lookup(int'(quant));

    always_comb begin
        if (hit_code.hit) begin
            code_bits = MAX_W'(hit_code.bits);
            code_len  = LEN_W'(hit_code.len);
        end else begin
            code_bits = {hit_code.bits, quant[ESC_W-1:0]};
            code_len  = LEN_W'(MAX_W);
        end
    end

endmodule

// File: rtl/qzh_bit_packer.sv
module qzh_bit_packer
    import qzh_pkg::*;
#(
    parameter int MAX_W = 19,
    parameter int LEN_W = $clog2(MAX_W + 1),
    parameter int ACC_W = MAX_W + BYTE_W - 1,
    parameter int CNT_W = $clog2(ACC_W + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [MAX_W-1:0]   in_bits,
    input  logic [LEN_W-1:0]   in_len,
    output logic               in_ready,
    input  logic               flush,
    output logic               empty,
    output logic               byte_valid,
    input  logic               byte_ready,
    output logic [BYTE_W-1:0]  byte_data
);

    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             full_byte;
    logic [ACC_W-1:0] aligned;
    logic [BYTE_W-1:0] head;

    assign full_byte = (cnt_q >= CNT_W'(BYTE_W));
    assign in_ready  = !full_byte;
    assign empty     = (cnt_q == '0);
    assign head      = acc_q[ACC_W-1 -: BYTE_W];

    assign byte_valid = full_byte || (flush && !empty);
    assign byte_data  = full_byte ? head : (head | (8'hFF >> cnt_q[2:0]));

    assign aligned = ACC_W'({in_bits, {(BYTE_W-1){1'b0}}}) << (LEN_W'(MAX_W) - in_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (byte_valid && byte_ready) begin
            acc_q <= acc_q << BYTE_W;
            cnt_q <= full_byte ? cnt_q - CNT_W'(BYTE_W) : '0;
        end else if (in_valid && in_ready) begin
            acc_q <= acc_q | (aligned >> cnt_q);
            cnt_q <= cnt_q + CNT_W'(in_len);
        end
    end

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(ACC_W));

endmodule

// File: rtl/qzh_block_coder.sv
module qzh_block_coder
    import qzh_pkg::*;
#(
    parameter int COEF_W = 15,
    parameter int QSHIFT = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     coef_we,
    input  logic [5:0]               coef_addr,
    input  logic signed [COEF_W-1:0] coef_data,
    input  logic                     start,
    output logic                     busy,
    output logic                     byte_valid,
    input  logic                     byte_ready,
    output logic [7:0]               byte_data
);

    localparam int ESC_W = COEF_W - QSHIFT;
    localparam int MAX_W = PFX_W + ESC_W;
    localparam int LEN_W = $clog2(MAX_W + 1);

    logic                     feed_valid;
    logic                     drain;
    logic                     take_ready;
    logic                     pack_empty;
    logic [ADDR_W-1:0]        raster_addr;
    logic signed [COEF_W-1:0] rd_coef;
    logic [MAX_W-1:0]         code_bits;
    logic [LEN_W-1:0]         code_len;

    qzh_zz_sequencer u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .take_ready  (take_ready),
        .pack_empty  (pack_empty),
        .feed_valid  (feed_valid),
        .drain       (drain),
        .busy        (busy),
        .raster_addr (raster_addr)
    );

    qzh_coef_bank #(.COEF_W(COEF_W)) u_bank (
        .clk     (clk),
        .wr_en   (coef_we),
        .lock    (busy),
        .wr_addr (coef_addr),
        .wr_data (coef_data),
        .rd_addr (raster_addr),
        .rd_data (rd_coef)
    );

    qzh_code_map #(
        .COEF_W (COEF_W),
        .QSHIFT (QSHIFT),
        .ESC_W  (ESC_W),
        .MAX_W  (MAX_W),
        .LEN_W  (LEN_W)
    ) u_map (
        .coef      (rd_coef),
        .code_bits (code_bits),
        .code_len  (code_len)
    );

    qzh_bit_packer #(
        .MAX_W (MAX_W),
        .LEN_W (LEN_W)
    ) u_pack (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (feed_valid),
        .in_bits    (code_bits),
        .in_len     (code_len),
        .in_ready   (take_ready),
        .flush      (drain),
        .empty      (pack_empty),
        .byte_valid (byte_valid),
        .byte_ready (byte_ready),
        .byte_data  (byte_data)
    );

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !byte_valid);

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !drain) |=> busy);

endmodule

// File: tb/qzh_block_coder_tb.sv
module qzh_block_coder_tb;

    localparam int CLK_P  = 10;
    localparam int COEF_W = 15;
    localparam int QSHIFT = 3;
    localparam int ESC_W  = COEF_W - QSHIFT;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     coef_we = 1'b0;
    logic [5:0]               coef_addr = '0;
    logic signed [COEF_W-1:0] coef_data = '0;
    logic                     start = 1'b0;
    logic                     busy;
    logic                     byte_valid;
    logic                     byte_ready = 1'b0;
    logic [7:0]               byte_data;

    int checks = 0;
    int failures = 0;
    int mem_m [64];
    int zz_m [64];
    bit exp_bits [$];
    logic [7:0] exp_bytes [$];

    always #(CLK_P/2) clk = ~clk;

    qzh_block_coder #(.COEF_W(COEF_W), .QSHIFT(QSHIFT)) u_dut (
        .clk (clk), .rst (rst), .coef_we (coef_we), .coef_addr (coef_addr),
        .coef_data (coef_data), .start (start), .busy (busy),
        .byte_valid (byte_valid), .byte_ready (byte_ready), .byte_data (byte_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    function automatic int qdiv(input int c);
        int d;
        d = 1 << QSHIFT;
        if (c >= 0) return c / d;
        return -((-c + d - 1) / d);
    endfunction

    task automatic push_bits(input int val, input int len);
        for (int i = len - 1; i >= 0; i--) exp_bits.push_back(bit'((val >> i) & 1));
    endtask

    task automatic push_code(input int q);
        case (q)
            -1:  push_bits(2'b00, 2);
            0:   push_bits(3'b100, 3);
            1:   push_bits(3'b010, 3);
            -2:  push_bits(3'b110, 3);
            2:   push_bits(4'b1110, 4);
            3:   push_bits(4'b1010, 4);
            5:   push_bits(4'b0110, 4);
            -3:  push_bits(5'b11110, 5);
            -5:  push_bits(5'b10110, 5);
            -10: push_bits(5'b01110, 5);
            -4:  push_bits(6'b101110, 6);
            -8:  push_bits(6'b101111, 6);
            -9:  push_bits(6'b111110, 6);
            6:   push_bits(6'b011111, 6);
            14:  push_bits(6'b011110, 6);
            144: push_bits(7'b1111110, 7);
            default: begin
                push_bits(7'b1111111, 7);
                push_bits(q & ((1 << ESC_W) - 1), ESC_W);
            end
        endcase
    endtask

    task automatic build_expected();
        logic [7:0] b;
        exp_bits.delete();
        exp_bytes.delete();
        for (int k = 0; k < 64; k++) push_code(qdiv(mem_m[zz_m[k]]));
        while (exp_bits.size() % 8 != 0) exp_bits.push_back(1'b1);
        for (int i = 0; i < exp_bits.size(); i += 8) begin
            b = '0;
            for (int j = 0; j < 8; j++) b[7-j] = exp_bits[i+j];
            exp_bytes.push_back(b);
        end
    endtask

    task automatic load_block();
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            coef_we = 1'b1;
            coef_addr = 6'(a);
            coef_data = COEF_W'(mem_m[a]);
        end
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic run_block(input string tag, input int ready_pct, input bit poke);
        int n;
        int cyc;
        bit prev_stall;
        logic [7:0] prev_data;
        build_expected();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R11 busy after start", busy, 1);
        n = 0;
        cyc = 0;
        prev_stall = 1'b0;
        prev_data = '0;
        while (busy && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            byte_ready = (($urandom % 100) < ready_pct);
            if (poke && cyc == 5) begin
                start = 1'b1;
                coef_we = 1'b1;
                coef_addr = 6'd0;
                coef_data = COEF_W'(mem_m[0] + 40);
            end else if (poke && cyc == 6) begin
                start = 1'b0;
                coef_we = 1'b0;
            end
            if (prev_stall) begin
                chk(byte_valid && byte_data == prev_data, "R9 stall hold", byte_data, prev_data);
            end
            if (byte_valid && byte_ready) begin
                if (n < exp_bytes.size())
                    chk(byte_data == exp_bytes[n], tag, byte_data, exp_bytes[n]);
                else
                    chk(1'b0, {tag, " extra byte"}, byte_data, 0);
                n++;
            end
            prev_stall = byte_valid && !byte_ready;
            prev_data = byte_data;
        end
        start = 1'b0;
        coef_we = 1'b0;
        chk(cyc < 5000, {tag, " timeout"}, cyc, 0);
        chk(n == exp_bytes.size(), {tag, " byte count R8"}, n, exp_bytes.size());
        byte_ready = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(!byte_valid && !busy, "R11 idle after block", byte_valid, 0);
        end
    endtask

    function automatic int pick_q();
        int tbl [16] = '{-1, 0, 1, -2, 2, 3, 5, -3, -5, -10, -4, -8, -9, 6, 14, 144};
        int r;
        r = $urandom % 10;
        if (r < 7) return tbl[$urandom % 16];
        if (r < 9) return int'($urandom % 41) - 20;
        return int'($urandom % 4096) - 2048;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int r;
        int c;
        int tv [16] = '{-1, 0, 1, -2, 2, 3, 5, -3, -5, -10, -4, -8, -9, 6, 14, 144};
        void'($urandom(32'd1207));
        r = 0;
        c = 0;
        for (int k = 0; k < 64; k++) begin
            zz_m[k] = r * 8 + c;
            if ((r + c) % 2 == 0) begin
                if (c == 7) r++; else if (r == 0) c++; else begin r--; c++; end
            end else begin
                if (r == 7) c++; else if (c == 0) r++; else begin r++; c--; end
            end
        end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!busy, "R1 busy reset", busy, 0);
        chk(!byte_valid, "R1 valid reset", byte_valid, 0);

        // R7: all zero block, 192 bits, no pad
        for (int a = 0; a < 64; a++) mem_m[a] = 0;
        load_block();
        run_block("R7 zero block", 100, 1'b0);

        // R4 R5 R2: every table entry with varied discarded remainders
        for (int a = 0; a < 64; a++) mem_m[a] = tv[a % 16] * 8 + (a % 8);
        load_block();
        run_block("R4/R5/R2 table block", 100, 1'b0);

        // R3: zigzag probe
        for (int a = 0; a < 64; a++) mem_m[a] = 0;
        mem_m[1] = -8;
        mem_m[8] = 8;
        mem_m[16] = 16;
        mem_m[63] = 40;
        load_block();
        run_block("R3 zigzag probe", 100, 1'b0);

        // R6: escape extremes
        for (int a = 0; a < 64; a++) mem_m[a] = 0;
        mem_m[0] = -16384;
        mem_m[1] = 16383;
        mem_m[8] = 7 * 8;
        mem_m[9] = -11 * 8 - 3;
        load_block();
        run_block("R6 escape", 100, 1'b0);

        // R8: 191 bits, one pad bit
        for (int a = 0; a < 64; a++) mem_m[a] = 0;
        mem_m[5] = -1;
        load_block();
        run_block("R8 pad", 100, 1'b0);

        // R9: heavy stalls
        for (int a = 0; a < 64; a++) mem_m[a] = pick_q() * 8 + int'($urandom % 8);
        load_block();
        run_block("R9 stalled block", 25, 1'b0);

        // R10: start and write while busy, then rerun without reload
        for (int a = 0; a < 64; a++) mem_m[a] = pick_q() * 8 + int'($urandom % 8);
        load_block();
        run_block("R10 poke while busy", 60, 1'b1);
        run_block("R10 rerun unchanged", 100, 1'b0);

        // R2: random blocks
        for (int b = 0; b < 6; b++) begin
            for (int a = 0; a < 64; a++) mem_m[a] = pick_q() * 8 + int'($urandom % 8);
            load_block();
            run_block("R2 random block", 70, 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule